// File: doc/BRIEF.md
# Microstepping Phase Sequencer

This block is the digital indexer for a two-phase stepper drive. It keeps the electrical rotor position in one counter. From that counter it derives, for each of the two phases, a winding-polarity gate pair and a percent current code that an external chopper uses as its target. It also drives a two-bit quadrant monitor and an off-origin flag. A step clock moves the position. The mode select chooses the step size, from a full step down to one sixteenth of a step, and it also chooses whether one or both clock edges count. A direction input sets the sense of travel. A return input sends the position back to origin. A low enable cuts both windings off and freezes the position.

The step clock, direction and return lines are treated as slow, asynchronous and possibly noisy. Each passes through a two-stage synchronizer and a counter filter before any edge is detected. When the mode changes, the position is not forced back to a grid point. On the next step it lands on the first position that is legal in the new mode, in the direction of travel. When a winding's polarity reverses, a short interval with both of its gates off separates the old and the new drive.

Top module: `phaseIndexer`

## Requirements
- R1: While rstN is low, all four winding gates are 0, quadMon is 2'b10 and offOrigin is 0. After release, the position is origin (index 0) whatever the mode. In any microstep mode, ratioA and ratioB then both read 71 and both polarities are positive.
- R2: The position is an index 0..63 over one electrical cycle. modeSel[2]=1 selects single-edge counting, and modeSel[1:0] = 0, 1, 2, 3 gives step sizes 16, 8, 4, 2. modeSel[2]=0 selects double-edge counting, and the same codes give step sizes 8, 4, 2, 1.
- R3: With modeSel[2]=1, only a rising edge of the filtered step clock advances the position. With modeSel[2]=0, both the rising and the falling edge advance it, so one clock period gives two steps.
- R4: With dirCw high, a step adds the step size modulo 64. With dirCw low, a step subtracts it modulo 64, so going backwards from index 0 wraps to 64 minus the step size.
- R5: When the index is not a multiple of the current step size, a forward step moves it to the next multiple above it. A reverse step moves it to the multiple just below it.
- R6: Let p = (index+8) mod 64, quadrant = p/16 and s = p mod 16. Phase A uses k = 16-s in even quadrants and k = s in odd quadrants. Phase B uses the other of the two. A is positive in quadrants 0 and 3, and B is positive in quadrants 0 and 1. A positive polarity drives gate pair 2'b01 and a negative one drives 2'b10. At step size 16, both ratios are 100.
- R7: Let c(k) for k = 0..16 be 0,10,20,29,38,47,56,63,71,77,83,88,92,96,98,100,100. The ratio for k=0 is 0. For k>0, locusSel 0 gives c. Setting 1 gives (c + k*100/16)/2. Setting 2 gives c + (100-c)/4, and setting 3 gives c + (100-c)/2, all in integer arithmetic.
- R8: quadMon reads 2'b10, 2'b01, 2'b00, 2'b11 for index/16 = 0, 1, 2, 3. offOrigin is 0 only at index 0.
- R9: A rising edge of the filtered return input, while enabled, sets the index to 0.
- R10: When enable is sampled low, all winding gates are 0 from the next cycle on and both ratios read 0. Step and return edges that occur while enable is low are lost, so the position, quadMon and offOrigin are held.
- R11: When a phase's desired polarity reverses, that phase's gates are both 0 for DEAD_CYC+1 cycles before the new gate turns on. The two gates of a phase are never on in consecutive cycles.
- R12: An input level that lasts fewer than FILT_LEN clock cycles after synchronization is ignored. The step clock, direction and return lines are taken as high at reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stepClk | input | 1 | Step clock, asynchronous |
| dirCw | input | 1 | Direction: 1 forward, 0 reverse |
| modeSel | input | 3 | Bit 2 edge select, bits 1:0 resolution code |
| locusSel | input | 2 | Current-vector locus select |
| retIn | input | 1 | Return to origin on rising edge |
| enable | input | 1 | Drive enable; low cuts off and holds |
| winA | output | 2 | Phase A gates: bit0 positive winding, bit1 complementary |
| winB | output | 2 | Phase B gates: bit0 positive winding, bit1 complementary |
| ratioA | output | 7 | Phase A current ratio in percent |
| ratioB | output | 7 | Phase B current ratio in percent |
| quadMon | output | 2 | Quadrant monitor |
| offOrigin | output | 1 | 0 at origin, 1 elsewhere |

## Verification
A corrupted position index shows up immediately and persistently at the ports. The monitor bits, the origin flag and both ratio codes all derive combinationally from it, and every later step compounds the error, so a single expected-value comparison after each step exposes it. A wrong dead-time counter or polarity register shows up only in the gate pattern during the DEAD_CYC+1 cycles after a reversal, so the gap length is measured cycle by cycle. Faults in the synchronizer and filter show up as missing or extra steps one filter latency after an input edge, or as a short pulse that is wrongly accepted.

// File: rtl/indexerPkg.sv
package indexerPkg;
  localparam int POS_W   = 6;   // one electrical cycle at 1/16 resolution
  localparam int SUB_W   = 4;   // position bits inside one quadrant
  localparam int K_W     = SUB_W + 1;
  localparam int RATIO_W = 7;   // percent code

  typedef struct packed {
    logic stepEv;
    logic stepFwd;
    logic retEv;
  } idxStrobe_t;

  function automatic logic [RATIO_W-1:0] circRatio(input logic [K_W-1:0] k);
    case (k)
      5'd0:  return 7'd0;
      5'd1:  return 7'd10;
      5'd2:  return 7'd20;
      5'd3:  return 7'd29;
      5'd4:  return 7'd38;
      5'd5:  return 7'd47;
      5'd6:  return 7'd56;
      5'd7:  return 7'd63;
      5'd8:  return 7'd71;
      5'd9:  return 7'd77;
      5'd10: return 7'd83;
      5'd11: return 7'd88;
      5'd12: return 7'd92;
      5'd13: return 7'd96;
      5'd14: return 7'd98;
      default: return 7'd100;
    endcase
  endfunction

  function automatic logic [RATIO_W-1:0] locusRatio(input logic [1:0] sel,
                                                    input logic [K_W-1:0] k);
    logic [RATIO_W-1:0] c;
    logic [10:0] lin;
    c   = circRatio(k);
    lin = (11'(k) * 11'd100) >> 4;
    if (k == '0) return '0;
    case (sel)
      2'd0:    return c;
      2'd1:    return 7'((11'(c) + lin) >> 1);
      2'd2:    return c + ((7'd100 - c) >> 2);
      default: return c + ((7'd100 - c) >> 1);
    endcase
  endfunction
endpackage

// File: rtl/indexCtrl.sv
module indexCtrl #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic dblEdge,
  input  logic stepClk,
  input  logic dirCw,
  input  logic retIn,
  output indexerPkg::idxStrobe_t strobe
);
  localparam int NIN   = 3;
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic [NIN-1:0] rawIn, clean;
  assign rawIn = {retIn, dirCw, stepClk};

  for (genvar i = 0; i < NIN; i++) begin : gCond
    logic [1:0]       syncQ;
    logic [CNT_W-1:0] cnt;
    logic             level;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= 2'b11;
        cnt   <= '0;
        level <= 1'b1;
      end else begin
        syncQ <= {syncQ[0], rawIn[i]};
        if (syncQ[1] == level) cnt <= '0;
        else if (cnt == CNT_W'(FILT_LEN - 1)) begin
          level <= syncQ[1];
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
      end
    end
    assign clean[i] = level;
  end

  logic stepPrev, retPrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepPrev <= 1'b1;
      retPrev  <= 1'b1;
    end else begin
      stepPrev <= clean[0];
      retPrev  <= clean[2];
    end
  end

  logic stepRise, stepAny, retRise;
  assign stepRise = clean[0] & ~stepPrev;
  assign stepAny  = clean[0] ^ stepPrev;
  assign retRise  = clean[2] & ~retPrev;

  always_comb begin
    strobe.stepEv  = enable & (dblEdge ? stepAny : stepRise);
    strobe.stepFwd = clean[1];
    strobe.retEv   = enable & retRise;
  end
endmodule

// File: rtl/indexPath.sv
module indexPath
  import indexerPkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [2:0]         modeSel,
  input  logic [1:0]         locusSel,
  input  idxStrobe_t         strobe,
  output logic [1:0]         winA,
  output logic [1:0]         winB,
  output logic [RATIO_W-1:0] ratioA,
  output logic [RATIO_W-1:0] ratioB,
  output logic [1:0]         quadMon,
  output logic               offOrigin
);
  localparam int DW = $clog2(DEAD_CYC + 1);

  logic [POS_W-1:0] pos, stepSize, stepMask, nextPos, phasePos;
  logic [2:0]       stepShift;
  logic             fullStep;

  assign stepShift = 3'd3 - {1'b0, modeSel[1:0]} + {2'b0, modeSel[2]};
  assign stepSize  = {{(POS_W-1){1'b0}}, 1'b1} << stepShift;
  assign stepMask  = stepSize - 1'b1;
  assign fullStep  = (stepShift == 3'(SUB_W));

  always_comb begin
    if (strobe.stepFwd)               nextPos = (pos & ~stepMask) + stepSize;
    else if ((pos & stepMask) == '0)  nextPos = pos - stepSize;
    else                              nextPos = pos & ~stepMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pos <= '0;
    else if (strobe.retEv)  pos <= '0;
    else if (strobe.stepEv) pos <= nextPos;
  end

  // electrical angle: origin sits half a quadrant in
  logic [SUB_W-1:0] sub;
  logic [1:0]       quad;
  logic [K_W-1:0]   kSin, kCos, kA, kB;
  assign phasePos = pos + POS_W'(1 << (SUB_W - 1));
  assign sub      = phasePos[SUB_W-1:0];
  assign quad     = phasePos[POS_W-1:SUB_W];
  assign kSin     = {1'b0, sub};
  assign kCos     = K_W'(1 << SUB_W) - kSin;
  assign kA       = quad[0] ? kSin : kCos;
  assign kB       = quad[0] ? kCos : kSin;

  logic [RATIO_W-1:0] magA, magB;
  assign magA   = fullStep ? 7'd100 : locusRatio(locusSel, kA);
  assign magB   = fullStep ? 7'd100 : locusRatio(locusSel, kB);
  assign ratioA = enable ? magA : '0;
  assign ratioB = enable ? magB : '0;

  logic [1:0] wantPos;
  assign wantPos = {~quad[1], ~(quad[1] ^ quad[0])};

  logic [1:0] gates [2];
  for (genvar ph = 0; ph < 2; ph++) begin : gDead
    logic          curPos;
    logic [DW-1:0] cnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        curPos    <= 1'b1;
        cnt       <= '0;
        gates[ph] <= 2'b00;
      end else if (!enable) begin
        cnt       <= '0;
        gates[ph] <= 2'b00;
      end else if (cnt != '0) begin
        cnt       <= cnt - 1'b1;
        gates[ph] <= 2'b00;
      end else if (wantPos[ph] != curPos) begin
        curPos    <= wantPos[ph];
        cnt       <= DW'(DEAD_CYC);
        gates[ph] <= 2'b00;
      end else begin
        gates[ph] <= curPos ? 2'b01 : 2'b10;
      end
    end
  end
  assign winA = gates[0];
  assign winB = gates[1];

  assign quadMon   = {~(pos[POS_W-1] ^ pos[POS_W-2]), pos[POS_W-2]};
  assign offOrigin = |pos;
endmodule

// File: rtl/phaseIndexer.sv
module phaseIndexer #(
  parameter int FILT_LEN = 3,
  parameter int DEAD_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stepClk,
  input  logic       dirCw,
  input  logic [2:0] modeSel,
  input  logic [1:0] locusSel,
  input  logic       retIn,
  input  logic       enable,
  output logic [1:0] winA,
  output logic [1:0] winB,
  output logic [6:0] ratioA,
  output logic [6:0] ratioB,
  output logic [1:0] quadMon,
  output logic       offOrigin
);
  indexerPkg::idxStrobe_t strobe;

  indexCtrl #(.FILT_LEN(FILT_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .dblEdge(~modeSel[2]),
    .stepClk(stepClk), .dirCw(dirCw), .retIn(retIn), .strobe(strobe)
  );

  indexPath #(.DEAD_CYC(DEAD_CYC)) uPath (
    .clk(clk), .rstN(rstN), .enable(enable), .modeSel(modeSel),
    .locusSel(locusSel), .strobe(strobe), .winA(winA), .winB(winB),
    .ratioA(ratioA), .ratioB(ratioB), .quadMon(quadMon), .offOrigin(offOrigin)
  );
endmodule

// File: rtl/indexerChecker.sv
module indexerChecker (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic [1:0] winA,
  input logic [1:0] winB,
  input logic [1:0] quadMon,
  input logic       offOrigin
);
  // R11
  dead_a_fwd_chk: assert property (@(posedge clk) disable iff (!rstN) winA[0] |=> !winA[1]);
  // R11
  dead_a_rev_chk: assert property (@(posedge clk) disable iff (!rstN) winA[1] |=> !winA[0]);
  // R11
  dead_b_fwd_chk: assert property (@(posedge clk) disable iff (!rstN) winB[0] |=> !winB[1]);
  // R11
  dead_b_rev_chk: assert property (@(posedge clk) disable iff (!rstN) winB[1] |=> !winB[0]);
  // R10
  cutoff_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (winA == 2'b00 && winB == 2'b00));
  // R10
  hold_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && $past(!enable)) |-> ($stable(quadMon) && $stable(offOrigin)));
  // R8
  origin_quad_chk: assert property (@(posedge clk) disable iff (!rstN)
    !offOrigin |-> quadMon == 2'b10);
  // R1
  reset_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !offOrigin);
endmodule

bind phaseIndexer indexerChecker uChk (
  .clk(clk), .rstN(rstN), .enable(enable), .winA(winA), .winB(winB),
  .quadMon(quadMon), .offOrigin(offOrigin)
);

// File: tb/tb_phaseIndexer.sv
`timescale 1ns/1ps
module tb_phaseIndexer;
  localparam int FILT_LEN = 3;
  localparam int DEAD_CYC = 4;
  localparam int SETTLE   = 24;

  logic clk = 1'b0;
  logic rstN, stepClk, dirCw, retIn, enable;
  logic [2:0] modeSel;
  logic [1:0] locusSel;
  logic [1:0] winA, winB, quadMon;
  logic [6:0] ratioA, ratioB;
  logic offOrigin;

  always #2.5 clk = ~clk;

  phaseIndexer #(.FILT_LEN(FILT_LEN), .DEAD_CYC(DEAD_CYC)) dut (
    .clk(clk), .rstN(rstN), .stepClk(stepClk), .dirCw(dirCw), .modeSel(modeSel),
    .locusSel(locusSel), .retIn(retIn), .enable(enable), .winA(winA), .winB(winB),
    .ratioA(ratioA), .ratioB(ratioB), .quadMon(quadMon), .offOrigin(offOrigin)
  );

  int nRun = 0, nFail = 0;
  int mIdx = 0;
  bit done = 0;
  int circT [17] = '{0,10,20,29,38,47,56,63,71,77,83,88,92,96,98,100,100};

  logic [20:0] expQ [$];
  string       tagQ [$];

  task automatic chk(input string tag, input int got, input int exp);
    nRun++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int locus(input int sel, input int k);
    int c;
    c = circT[k];
    if (k == 0) return 0;
    case (sel)
      0: return c;
      1: return (c + (k * 100) / 16) / 2;
      2: return c + (100 - c) / 4;
      default: return c + (100 - c) / 2;
    endcase
  endfunction

  function automatic int curStep();
    return 1 << (3 - int'(modeSel[1:0]) + int'(modeSel[2]));
  endfunction

  function automatic logic [20:0] expected();
    int q, qq, s, ka, kb, ra, rb;
    logic [1:0] wa, wb, qm;
    q = (mIdx + 8) % 64; qq = q / 16; s = q % 16;
    ka = (qq % 2) ? s : 16 - s;
    kb = (qq % 2) ? 16 - s : s;
    ra = (curStep() == 16) ? 100 : locus(int'(locusSel), ka);
    rb = (curStep() == 16) ? 100 : locus(int'(locusSel), kb);
    wa = (qq == 0 || qq == 3) ? 2'b01 : 2'b10;
    wb = (qq < 2) ? 2'b01 : 2'b10;
    if (!enable) begin ra = 0; rb = 0; wa = 2'b00; wb = 2'b00; end
    case (mIdx / 16)
      0: qm = 2'b10;
      1: qm = 2'b01;
      2: qm = 2'b00;
      default: qm = 2'b11;
    endcase
    return {wa, wb, 7'(ra), 7'(rb), qm, (mIdx != 0)};
  endfunction

  function automatic void modelStep();
    int st;
    st = curStep();
    if (dirCw) mIdx = ((mIdx / st) * st + st) % 64;
    else if (mIdx % st == 0) mIdx = (mIdx - st + 64) % 64;
    else mIdx = (mIdx / st) * st;
  endfunction

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic pushExp(input string tag);
    expQ.push_back(expected());
    tagQ.push_back(tag);
    while (expQ.size() != 0) @(negedge clk);
  endtask

  // monitor: compare outputs against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        logic [20:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk({t, " winA"},      int'(winA),      int'(e[20:19]));
        chk({t, " winB"},      int'(winB),      int'(e[18:17]));
        chk({t, " ratioA"},    int'(ratioA),    int'(e[16:10]));
        chk({t, " ratioB"},    int'(ratioB),    int'(e[9:3]));
        chk({t, " quadMon"},   int'(quadMon),   int'(e[2:1]));
        chk({t, " offOrigin"}, int'(offOrigin), int'(e[0]));
      end
    end
  end

  task automatic toggleStep(input string tag);
    stepClk = ~stepClk;
    if (!modeSel[2] || stepClk) modelStep();
    settle();
    pushExp(tag);
  endtask

  task automatic advance(input string tag);
    if (modeSel[2] && stepClk) begin stepClk = 1'b0; settle(); end
    toggleStep(tag);
  endtask

  task automatic setMode(input logic [2:0] m);
    modeSel = m; settle();
  endtask

  task automatic pulseRet();
    retIn = 1'b0; settle(); retIn = 1'b1;
    if (enable) mIdx = 0;
    settle();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nFail++; nRun++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; stepClk = 1'b1; dirCw = 1'b1; retIn = 1'b1; enable = 1'b1;
    modeSel = 3'b111; locusSel = 2'd0;
    repeat (6) @(negedge clk);
    chk("R1 gates in reset", int'({winA, winB}), 0);
    chk("R1 quadMon in reset", int'(quadMon), 2);
    chk("R1 offOrigin in reset", int'(offOrigin), 0);
    rstN = 1'b1;
    settle();
    pushExp("R1 after release");

    // R2 single-edge 2W1-2 (step 2), R6 through a quadrant crossing
    for (int i = 0; i < 3; i++) advance("R2 step2 fwd");
    for (int i = 0; i < 2; i++) advance("R6 cross quadrant");

    // R4 reverse
    dirCw = 1'b0; settle();
    advance("R4 reverse step");

    // R9 return then R4 wrap in full-step mode
    pulseRet(); pushExp("R9 return origin");
    setMode(3'b100);
    advance("R4 wrap from origin");
    pushExp("R6 full step 100");

    // R11 dead gap: index 48 -> 0 flips phase B only
    dirCw = 1'b1; settle();
    begin
      int gap;
      stepClk = 1'b0; settle();
      stepClk = 1'b1; modelStep();
      gap = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (winB == 2'b00) gap++;
      end
      chk("R11 dead gap cycles", gap, DEAD_CYC + 1);
      pushExp("R11 after reversal");
    end

    // R8 all quadrants in full-step mode
    for (int i = 0; i < 4; i++) advance("R8 quadrant walk");

    // R3 double edge 1/16 step
    setMode(3'b011);
    toggleStep("R3 falling edge steps");
    toggleStep("R3 rising edge steps");
    toggleStep("R3 third edge");

    // R5 snap forward then reverse
    setMode(3'b101);
    advance("R5 snap forward");
    setMode(3'b011);
    dirCw = 1'b0; settle();
    toggleStep("R5 fine reverse");
    setMode(3'b101);
    advance("R5 snap reverse");

    // R7 loci at index 2
    dirCw = 1'b1; setMode(3'b111);
    pulseRet();
    advance("R7 position");
    for (int l = 0; l < 4; l++) begin
      locusSel = 2'(l); settle();
      pushExp("R7 locus ratios");
    end
    advance("R7 next position");
    locusSel = 2'd1; settle();
    pushExp("R7 inner locus");
    locusSel = 2'd0; settle();

    // R10 disable holds
    enable = 1'b0; settle();
    pushExp("R10 cutoff");
    stepClk = 1'b0; settle(); stepClk = 1'b1; settle();
    pulseRet();
    pushExp("R10 edges ignored");
    enable = 1'b1; settle();
    pushExp("R10 resume");

    // R12 short pulses ignored
    @(negedge clk); stepClk = 1'b0;
    repeat (FILT_LEN - 1) @(negedge clk);
    stepClk = 1'b1; settle();
    pushExp("R12 short step pulse");
    @(negedge clk); retIn = 1'b0;
    repeat (FILT_LEN - 1) @(negedge clk);
    retIn = 1'b1; settle();
    pushExp("R12 short return pulse");

    // R1 reset mid-run in a microstep mode
    setMode(3'b110);
    advance("R1 pre-reset move");
    @(negedge clk); rstN = 1'b0; mIdx = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1; settle();
    pushExp("R1 reset mid-run");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule